// File: doc/BRIEF.md
# Interrupt Restart Injector

This block sits next to an 8-bit processor whose address, data and status share one multiplexed bus. A peripheral raises a request line. The block captures the rising edge of that request and drives the processor's interrupt input. The processor reports the current time-state as a 3-bit state code. The block watches that code for the acknowledge value, then waits for the data phase of the instruction fetch that follows.

During that data phase the block drives a one-byte restart instruction onto the data bus and keeps memory from answering. The restart byte carries a programmable 3-bit vector, so control passes to address vector×8. The processor saves no registers or flags when it takes the interrupt. The block therefore keeps no processor state and makes no assumption that any is preserved. A request edge that arrives while a restart is being delivered is held, and it is raised again as soon as that delivery is over.

Top module: `intr_jam_ctrl`

## Requirements
- R1: The request input passes through `SYNC_STAGES` flip-flops. Only a 0-to-1 transition of the synchronised request marks an interrupt as pending. A request held high does not mark a second one.
- R2: `irq_o` is high while a pending interrupt waits for acknowledgement. It goes low on the clock edge that samples state code 3'b011 (the acknowledge value).
- R3: State code 3'b011 has no effect when no interrupt is being requested.
- R4: After acknowledgement, `bus_drive_o` is high in every cycle of the first fetch data phase, and in no other cycle. A fetch data phase is state code 3'b100 together with `fetch_cycle_i` high, over consecutive cycles.
- R5: Data phases with `fetch_cycle_i` low are not jammed. The block keeps waiting for a fetch data phase.
- R6: While the bus is driven, `jam_byte_o` equals {2'b00, V, 3'b101}. V is the value of `vec_i` sampled at acknowledgement. Later changes of `vec_i` do not alter it.
- R7: `mem_rd_en_o` follows `mem_rd_req_i`, except that it is forced low whenever `bus_drive_o` is high.
- R8: A request edge seen during acknowledgement or delivery is held pending. `irq_o` rises again as soon as the current data phase ends.
- R9: While `rst_n` is low, `irq_o` and `bus_drive_o` are low and nothing is pending.
- R10: `jam_byte_o` is zero whenever `bus_drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Interrupt request from a peripheral (asynchronous) |
| vec_i | input | VEC_W | Restart vector to be jammed |
| cpu_state_i | input | CODE_W | Time-state code reported by the processor |
| fetch_cycle_i | input | 1 | Current machine cycle is an instruction fetch |
| mem_rd_req_i | input | 1 | Memory read enable requested by the bus decode |
| irq_o | output | 1 | Interrupt input of the processor |
| bus_drive_o | output | 1 | Enables the jam byte onto the data bus |
| jam_byte_o | output | VEC_W+5 | Restart opcode to place on the bus |
| mem_rd_en_o | output | 1 | Gated memory read enable |

## Verification
A sequencer stuck in the wrong state shows at the ports within one cycle of the next acknowledge code or data phase. It appears as an interrupt line that stays high, a drive enable that never comes, or a drive enable in the wrong phase. A corrupted pending flag shows as a missing or doubled interrupt within a few cycles of a request edge. A wrongly latched vector shows in the jammed byte on the first driven cycle. The bench checks each of these outputs against its reference model on every clock, so any such fault is reported in the cycle in which it first reaches a port.

// File: rtl/ijc_pkg.sv
package ijc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ASK   = 2'd1,
    SEQ_ARMED = 2'd2,
    SEQ_JAM   = 2'd3
  } seq_t;

  localparam logic [1:0] RST_HEAD = 2'b00;
  localparam logic [2:0] RST_TAIL = 3'b101;

endpackage

// File: rtl/ijc_req_sync.sv
module ijc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic req_rise
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = req_async;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], req_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= sh_q[STAGES-1];
    end
  end

  assign req_rise = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ijc_pending.sv
module ijc_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (take_i) pend_d = 1'b0;
    if (set_i)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ijc_seq.sv
module ijc_seq
  import ijc_pkg::*;
#(
  parameter int VEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_i,
  input  logic             ack_seen_i,
  input  logic             fetch_data_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             take_o,
  output logic             ask_o,
  output logic             drive_o,
  output logic [VEC_W-1:0] vec_o
);
  seq_t             st_q, st_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_en;

  assign take_o = (st_q == SEQ_ASK) && ack_seen_i;
  assign vec_en = take_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE:  if (pend_i) st_d = SEQ_ASK;
      SEQ_ASK:   if (ack_seen_i) st_d = SEQ_ARMED;
      SEQ_ARMED: if (fetch_data_i) st_d = SEQ_JAM;
      SEQ_JAM:   if (!fetch_data_i) st_d = pend_i ? SEQ_ASK : SEQ_IDLE;
      default:   st_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    vec_d = vec_q;
    if (vec_en) vec_d = vec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      vec_q <= '0;
    end else begin
      st_q  <= st_d;
      vec_q <= vec_d;
    end
  end

  assign ask_o   = (st_q == SEQ_ASK);
  assign drive_o = ((st_q == SEQ_ARMED) || (st_q == SEQ_JAM)) && fetch_data_i;
  assign vec_o   = vec_q;
endmodule

// File: rtl/ijc_jam_out.sv
module ijc_jam_out
  import ijc_pkg::*;
#(
  parameter int VEC_W = 3
) (
  input  logic             drive_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             rd_req_i,
  output logic [VEC_W+4:0] byte_o,
  output logic             rd_en_o
);
  always_comb begin
    byte_o = '0;
    if (drive_i) byte_o = {RST_HEAD, vec_i, RST_TAIL};
  end

  assign rd_en_o = rd_req_i & ~drive_i;
endmodule

// File: rtl/intr_jam_ctrl.sv
module intr_jam_ctrl #(
  parameter int             SYNC_STAGES = 2,
  parameter int             VEC_W       = 3,
  parameter int             CODE_W      = 3,
  parameter logic [CODE_W-1:0] ACK_CODE  = 3'b011,
  parameter logic [CODE_W-1:0] DATA_CODE = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [CODE_W-1:0] cpu_state_i,
  input  logic              fetch_cycle_i,
  input  logic              mem_rd_req_i,
  output logic              irq_o,
  output logic              bus_drive_o,
  output logic [VEC_W+4:0]  jam_byte_o,
  output logic              mem_rd_en_o
);
  logic             rise;
  logic             pend;
  logic             take;
  logic             ack_seen;
  logic             fetch_data;
  logic [VEC_W-1:0] vec_held;

  assign ack_seen   = (cpu_state_i == ACK_CODE);
  assign fetch_data = (cpu_state_i == DATA_CODE) && fetch_cycle_i;

  ijc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_async (irq_req_i),
    .req_rise  (rise)
  );

  ijc_pending u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (rise),
    .take_i (take),
    .pend_o (pend)
  );

  ijc_seq #(.VEC_W(VEC_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_i       (pend),
    .ack_seen_i   (ack_seen),
    .fetch_data_i (fetch_data),
    .vec_i        (vec_i),
    .take_o       (take),
    .ask_o        (irq_o),
    .drive_o      (bus_drive_o),
    .vec_o        (vec_held)
  );

  ijc_jam_out #(.VEC_W(VEC_W)) u_out (
    .drive_i  (bus_drive_o),
    .vec_i    (vec_held),
    .rd_req_i (mem_rd_req_i),
    .byte_o   (jam_byte_o),
    .rd_en_o  (mem_rd_en_o)
  );
endmodule

// File: rtl/ijc_checker.sv
module ijc_checker #(
  parameter int             VEC_W     = 3,
  parameter int             CODE_W    = 3,
  parameter logic [CODE_W-1:0] ACK_CODE  = 3'b011,
  parameter logic [CODE_W-1:0] DATA_CODE = 3'b100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] cpu_state_i,
  input logic              fetch_cycle_i,
  input logic              irq_o,
  input logic              bus_drive_o,
  input logic [VEC_W+4:0]  jam_byte_o,
  input logic              mem_rd_en_o
);
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_o |-> !mem_rd_en_o); // R7
  AST_DRIVE_IN_FETCH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_o |-> (cpu_state_i == DATA_CODE && fetch_cycle_i)); // R4
  AST_IRQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && cpu_state_i == ACK_CODE) |=> !irq_o); // R2
  AST_NO_DRIVE_WHILE_ASKING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !bus_drive_o); // R4
  AST_RESTART_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_o |-> (jam_byte_o[2:0] == 3'b101 && jam_byte_o[VEC_W+4:VEC_W+3] == 2'b00)); // R6
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive_o |-> (jam_byte_o == '0)); // R10
endmodule

bind intr_jam_ctrl ijc_checker #(
  .VEC_W(VEC_W), .CODE_W(CODE_W), .ACK_CODE(ACK_CODE), .DATA_CODE(DATA_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_state_i(cpu_state_i), .fetch_cycle_i(fetch_cycle_i),
  .irq_o(irq_o), .bus_drive_o(bus_drive_o), .jam_byte_o(jam_byte_o), .mem_rd_en_o(mem_rd_en_o)
);

// File: tb/tb_intr_jam_ctrl.sv
`timescale 1ns/1ps
module tb_intr_jam_ctrl;
  localparam int NS = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req;
  logic [2:0] vec;
  logic [2:0] code;
  logic       fetch;
  logic       rdq;
  logic       irq, drv, rd_en;
  logic [7:0] jbyte;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int         m_sync[NS];
  int         m_last;
  int         m_pend;
  int         m_mode; // 0 idle, 1 asking, 2 waiting for fetch data, 3 delivering
  logic [2:0] m_vec;

  always #4 clk = ~clk;

  intr_jam_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .vec_i(vec), .cpu_state_i(code),
    .fetch_cycle_i(fetch), .mem_rd_req_i(rdq), .irq_o(irq), .bus_drive_o(drv),
    .jam_byte_o(jbyte), .mem_rd_en_o(rd_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int in_fd();
    return (code == 3'b100 && fetch) ? 1 : 0;
  endfunction

  task automatic model_clock();
    int edge_now, take, fd;
    edge_now = (m_sync[NS-1] == 1 && m_last == 0) ? 1 : 0;
    take     = (m_mode == 1 && code == 3'b011) ? 1 : 0;
    fd       = in_fd();
    case (m_mode)
      0: if (m_pend != 0) m_mode = 1;
      1: if (take != 0) m_mode = 2;
      2: if (fd != 0) m_mode = 3;
      default: if (fd == 0) m_mode = (m_pend != 0) ? 1 : 0;
    endcase
    if (take != 0) m_vec = vec;
    m_pend = (edge_now != 0) ? 1 : ((take != 0) ? 0 : m_pend);
    m_last = m_sync[NS-1];
    for (int i = NS-1; i > 0; i--) m_sync[i] = m_sync[i-1];
    m_sync[0] = req;
  endtask

  task automatic compare();
    int e_drv;
    e_drv = ((m_mode == 2 || m_mode == 3) && in_fd() != 0) ? 1 : 0;
    check("R1 R2 R3 R8 irq", irq, (m_mode == 1) ? 1 : 0);
    check("R4 R5 drive", drv, e_drv);
    check("R6 R10 byte", jbyte, (e_drv != 0) ? {2'b00, m_vec, 3'b101} : 0);
    check("R7 rd_en", rd_en, (rdq && e_drv == 0) ? 1 : 0);
  endtask

  task automatic step(input logic r, input logic [2:0] c, input logic f,
                      input logic rd, input logic [2:0] v);
    @(negedge clk);
    model_clock();
    req = r; code = c; fetch = f; rdq = rd; vec = v;
    #1;
    compare();
  endtask

  task automatic idle(input int n, input logic r);
    for (int i = 0; i < n; i++) step(r, 3'b000, 1'b0, 1'b1, vec);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 0; vec = 3'd5; code = 0; fetch = 0; rdq = 1;
    for (int i = 0; i < NS; i++) m_sync[i] = 0;
    m_last = 0; m_pend = 0; m_mode = 0; m_vec = 0;
    repeat (3) @(negedge clk);
    req = 1; // request during reset must leave nothing pending after release
    #1;
    check("R9 irq in reset", irq, 0);
    check("R9 drive in reset", drv, 0);
    req = 0;
    @(negedge clk); rst_n = 1'b1; #1;
    compare();
    idle(4, 0);
    // R3: acknowledge code with nothing requested
    step(0, 3'b011, 1'b0, 1'b1, 3'd5);
    idle(2, 0);
    step(0, 3'b100, 1'b1, 1'b1, 3'd5);
    idle(2, 0);
    // R1 R2 R5 R6 R7: one request, held high (no re-trigger)
    idle(6, 1);
    step(1, 3'b011, 1'b0, 1'b1, 3'd5);
    step(1, 3'b010, 1'b0, 1'b1, 3'd2);
    step(1, 3'b100, 1'b0, 1'b1, 3'd2);
    step(1, 3'b100, 1'b1, 1'b1, 3'd1);
    step(1, 3'b100, 1'b1, 1'b1, 3'd0);
    idle(6, 1);
    // R8: new edge during delivery
    idle(2, 0);
    idle(5, 1);
    step(0, 3'b011, 1'b0, 1'b1, 3'd7);
    step(1, 3'b010, 1'b0, 1'b0, 3'd0);
    step(1, 3'b100, 1'b1, 1'b1, 3'd0);
    step(1, 3'b100, 1'b1, 1'b1, 3'd0);
    step(1, 3'b100, 1'b1, 1'b1, 3'd0);
    step(1, 3'b000, 1'b0, 1'b1, 3'd0);
    idle(3, 1);
    step(1, 3'b011, 1'b0, 1'b1, 3'd0);
    step(1, 3'b100, 1'b1, 1'b1, 3'd3);
    idle(4, 0);
    // mixed patterns
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c;
      int k;
      k = $urandom_range(0, 9);
      c = (k < 3) ? 3'b011 : (k < 6) ? 3'b100 : 3'($urandom_range(0, 7));
      step(($urandom_range(0, 7) == 0) ? ~req : req, c, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule